// File: doc/BRIEF.md
# Four-Entry Instruction Address Translation Cache

The block is a small, fully associative translation cache for instruction fetches. It holds four page entries. Each entry has a virtual page number, an address-space tag, a global (shared) flag, a physical page number, a page size code, protection bits and a valid bit. A fetch address is compared against all four entries in the same cycle. The block reports a single hit, a miss or a multiple hit. On a single hit it returns the matching slot, its protection bits, its physical page number and the translated physical address. The surrounding fetch unit raises a lookup strobe for each fetch. It refills the cache from a larger unified table through a valid/ready fill port whenever a lookup misses.

Replacement uses a six-bit pairwise recency state. The state records, for each of the six pairs of slots, which slot of the pair was touched more recently. A hit or a fill touches one slot and forces the three pair bits that involve it. The slot to replace is decoded from the state with a fixed priority. If the state holds no legal pattern, slot 0 is chosen and an error flag is raised. Control software can load the six state bits directly. The state is exposed so that it can sit in the top bits of a control register.

Back-pressure on the fill port works as follows. A fill transfers on a rising edge where both `fill_valid` and `fill_ready` are high. `fill_ready` is low exactly in the cycles where `lru_wr_en` is high. A producer that sees `fill_ready` low must keep `fill_valid` and the fill fields stable until the transfer happens. Lookup is purely combinational and has no handshake.

Top module: `ifetch_tlb4`

## Requirements
- R1: After reset every slot is invalid, `lru_state` is 6'b000000, `victim_idx` is 3, `lru_err` is 0, and any lookup reports a miss.
- R2: A touch of a slot updates the state bits `lru_state[5:0]`, where bit 5 is the most significant. Slot 0 clears bits 5, 4 and 3. Slot 1 sets bit 5 and clears bits 2 and 1. Slot 2 sets bits 4 and 2 and clears bit 0. Slot 3 sets bits 3, 1 and 0. A touch happens on a single hit with `lkp_en` high, or on an accepted fill. A fill takes precedence over a hit in the same cycle. The updated state is visible after the same clock edge.
- R3: The victim is decoded in priority order. Bits 5, 4 and 3 all one give slot 0. Otherwise bit 5 zero with bits 2 and 1 one gives slot 1. Otherwise bits 4 and 2 zero with bit 0 one gives slot 2. Otherwise bits 3, 1 and 0 all zero give slot 3. When none of these patterns applies, the victim is slot 0 and `lru_err` is 1.
- R4: An entry matches only when it is valid. It must also pass the tag check, which passes when its shared flag is set, when `use_asid` is 0, or when its tag equals `cur_asid`.
- R5: An entry covers a naturally aligned page. The page base is the virtual page number shifted left by 10 and aligned to the page size. The page size code is 0 for 1 KiB, 1 for 4 KiB, 2 for 64 KiB and 3 for 1 MiB. On a hit, `hit_pa` is the page-aligned physical page number, shifted left by 10, ORed with the in-page offset of `lkp_va`.
- R6: When two or more entries match, `multi_hit` is 1, `hit` and `miss` are 0, and `lru_state` is not changed by that lookup.
- R7: An accepted fill writes the fill fields into slot `victim_idx` as it was decoded in the cycle of the transfer. The entry can be looked up from the next cycle on.
- R8: When `lru_wr_en` is 1, `lru_state` takes `lru_wr_data` at the clock edge, overriding any touch, and `fill_ready` is 0 in that cycle.
- R9: With `lkp_en` 0, `hit`, `miss` and `multi_hit` are all 0 and a matching address does not change `lru_state`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lkp_en | input | 1 | A fetch lookup is made this cycle |
| lkp_va | input | 32 | Fetch virtual address |
| cur_asid | input | 8 | Current address-space tag |
| use_asid | input | 1 | Enables the tag check |
| fill_valid | input | 1 | Fill entry offered |
| fill_ready | output | 1 | Fill can be accepted |
| fill_vpn | input | 22 | Fill virtual page number |
| fill_asid | input | 8 | Fill address-space tag |
| fill_ppn | input | 19 | Fill physical page number |
| fill_size | input | 2 | Fill page size code |
| fill_prot | input | 2 | Fill protection bits |
| fill_shr | input | 1 | Fill shared flag |
| fill_ent_vld | input | 1 | Valid bit written with the fill |
| lru_wr_en | input | 1 | Load the recency state |
| lru_wr_data | input | 6 | Value to load into the recency state |
| hit | output | 1 | Exactly one entry matches |
| miss | output | 1 | No entry matches |
| multi_hit | output | 1 | Several entries match |
| hit_idx | output | 2 | Matching slot |
| hit_prot | output | 2 | Protection bits of the matching slot |
| hit_ppn | output | 19 | Physical page number of the matching slot |
| hit_pa | output | 29 | Translated physical address |
| lru_state | output | 6 | Recency state, bit 5 is the top control-register bit |
| victim_idx | output | 2 | Slot the next fill will replace |
| lru_err | output | 1 | Recency state holds no legal pattern |

## Verification
The assertions assume that `rst_n` is held low for at least one clock edge before any lookup or fill. They also assume that the fill fields are stable while `fill_valid` waits on `fill_ready`. The bench meets both conditions. It changes inputs only on falling edges, and it never raises `fill_valid` in a cycle where it loads the recency state. The multi-hit assertion assumes nothing else changes the state in the same cycle. The bench therefore runs its overlap lookups with the fill and load strobes low. Every one of the 64 state values is loaded on purpose, so the illegal patterns are reached only through the load port.

// File: rtl/itlb_pkg.sv
package itlb_pkg;
  localparam int VA_W     = 32;
  localparam int PG_SHIFT = 10;
  localparam int VPN_W    = VA_W - PG_SHIFT;
  localparam int PPN_W    = 19;
  localparam int PA_W     = PPN_W + PG_SHIFT;
  localparam int ASID_W   = 8;
  localparam int N_ENT    = 4;
  localparam int IDX_W    = $clog2(N_ENT);
  localparam int CNT_W    = IDX_W + 1;
  localparam int LRU_W    = 6;
  localparam int PROT_W   = 2;

  typedef enum logic [1:0] {
    PG_1K  = 2'd0,
    PG_4K  = 2'd1,
    PG_64K = 2'd2,
    PG_1M  = 2'd3
  } pg_size_e;

  typedef struct packed {
    logic              vld;
    logic              shr;
    logic [ASID_W-1:0] asid;
    logic [VPN_W-1:0]  vpn;
    logic [PPN_W-1:0]  ppn;
    pg_size_e          size;
    logic [PROT_W-1:0] prot;
  } tlb_ent_t;

  // In-page offset mask for each page size
  function automatic logic [VA_W-1:0] off_mask(input pg_size_e s);
    logic [VA_W-1:0] m;
    case (s)
      PG_1K:   m = VA_W'(32'h0000_03FF);
      PG_4K:   m = VA_W'(32'h0000_0FFF);
      PG_64K:  m = VA_W'(32'h0000_FFFF);
      default: m = VA_W'(32'h000F_FFFF);
    endcase
    return m;
  endfunction
endpackage

// File: rtl/itlb_cmp.sv
module itlb_cmp
  import itlb_pkg::*;
(
  input  tlb_ent_t          ent,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              use_asid,
  output logic              match,
  output logic [PA_W-1:0]   pa
);
  logic [VA_W-1:0] msk;
  logic [VA_W-1:0] base;
  logic [PA_W-1:0] pbase;
  logic            asid_ok;
  logic            rng_ok;

  assign msk     = off_mask(ent.size);
  assign base    = {ent.vpn, {PG_SHIFT{1'b0}}} & ~msk;
  assign pbase   = {ent.ppn, {PG_SHIFT{1'b0}}} & ~msk[PA_W-1:0];
  assign asid_ok = ent.shr | ~use_asid | (ent.asid == cur_asid);
  assign rng_ok  = ((va & ~msk) == base);
  assign match   = ent.vld & asid_ok & rng_ok;
  assign pa      = pbase | (va[PA_W-1:0] & msk[PA_W-1:0]);
endmodule

// File: rtl/itlb_store.sv
module itlb_store
  import itlb_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       widx,
  input  tlb_ent_t               wdata,
  output tlb_ent_t [N_ENT-1:0]   ents
);
  for (genvar g = 0; g < N_ENT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ents[g] <= '0;
      end else if (we && (widx == IDX_W'(g))) begin
        ents[g] <= wdata;
      end
    end

    // R7: a written slot holds the fill data after the edge
    p_slot_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we && widx == IDX_W'(g)) |=> (ents[g] == $past(wdata)));
  end
endmodule

// File: rtl/itlb_plru.sv
module itlb_plru
  import itlb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [LRU_W-1:0] wr_data,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  output logic [LRU_W-1:0] state,
  output logic [IDX_W-1:0] victim,
  output logic             err
);
  function automatic logic [LRU_W-1:0] touch(input logic [LRU_W-1:0] s,
                                              input logic [IDX_W-1:0] i);
    logic [LRU_W-1:0] n;
    case (i)
      2'd0:    n = s & 6'b000111;
      2'd1:    n = (s | 6'b100000) & 6'b111001;
      2'd2:    n = (s | 6'b010100) & 6'b111110;
      default: n = s | 6'b001011;
    endcase
    return n;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= '0;
    end else if (wr_en) begin
      state <= wr_data;
    end else if (upd_en) begin
      state <= touch(state, upd_idx);
    end
  end

  always_comb begin
    err = 1'b0;
    if (state[5] && state[4] && state[3]) begin
      victim = 2'd0;
    end else if (!state[5] && state[2] && state[1]) begin
      victim = 2'd1;
    end else if (!state[4] && !state[2] && state[0]) begin
      victim = 2'd2;
    end else if (!state[3] && !state[1] && !state[0]) begin
      victim = 2'd3;
    end else begin
      victim = 2'd0;
      err    = 1'b1;
    end
  end

  p_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (state == $past(wr_data)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !upd_en) |=> $stable(state));
  p_touch0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && upd_en && upd_idx == 2'd0) |=> (state[5:3] == 3'b000));
  p_touch3_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && upd_en && upd_idx == 2'd3) |=> (state[3] && state[1] && state[0]));
  p_err_slot0_r3: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (victim == 2'd0));
endmodule

// File: rtl/ifetch_tlb4.sv
module ifetch_tlb4
  import itlb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_en,
  input  logic [31:0]       lkp_va,
  input  logic [7:0]        cur_asid,
  input  logic              use_asid,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [21:0]       fill_vpn,
  input  logic [7:0]        fill_asid,
  input  logic [18:0]       fill_ppn,
  input  logic [1:0]        fill_size,
  input  logic [1:0]        fill_prot,
  input  logic              fill_shr,
  input  logic              fill_ent_vld,
  input  logic              lru_wr_en,
  input  logic [5:0]        lru_wr_data,
  output logic              hit,
  output logic              miss,
  output logic              multi_hit,
  output logic [1:0]        hit_idx,
  output logic [1:0]        hit_prot,
  output logic [18:0]       hit_ppn,
  output logic [28:0]       hit_pa,
  output logic [5:0]        lru_state,
  output logic [1:0]        victim_idx,
  output logic              lru_err
);
  tlb_ent_t [N_ENT-1:0] ents;
  tlb_ent_t             fill_ent;
  logic [N_ENT-1:0]     match;
  logic [PA_W-1:0]      pa_v [N_ENT];
  logic [CNT_W-1:0]     n_match;
  logic [IDX_W-1:0]     sel;
  logic                 fill_acc;
  logic                 upd_en;
  logic [IDX_W-1:0]     upd_idx;

  assign fill_ready = ~lru_wr_en;
  assign fill_acc   = fill_valid & fill_ready;

  always_comb begin
    fill_ent      = '0;
    fill_ent.vld  = fill_ent_vld;
    fill_ent.shr  = fill_shr;
    fill_ent.asid = fill_asid;
    fill_ent.vpn  = fill_vpn;
    fill_ent.ppn  = fill_ppn;
    fill_ent.size = pg_size_e'(fill_size);
    fill_ent.prot = fill_prot;
  end

  itlb_store u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (fill_acc),
    .widx  (victim_idx),
    .wdata (fill_ent),
    .ents  (ents)
  );

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    itlb_cmp u_cmp (
      .ent      (ents[g]),
      .va       (lkp_va),
      .cur_asid (cur_asid),
      .use_asid (use_asid),
      .match    (match[g]),
      .pa       (pa_v[g])
    );

    // R4: an invalid slot never matches
    p_invalid_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !ents[g].vld |-> !match[g]);
  end

  always_comb begin
    n_match = '0;
    sel     = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      n_match = n_match + CNT_W'(match[i]);
      if (match[i]) sel = IDX_W'(i);
    end
  end

  assign hit       = lkp_en & (n_match == CNT_W'(1));
  assign miss      = lkp_en & (n_match == '0);
  assign multi_hit = lkp_en & (n_match > CNT_W'(1));
  assign hit_idx   = sel;
  assign hit_prot  = ents[sel].prot;
  assign hit_ppn   = ents[sel].ppn;
  assign hit_pa    = pa_v[sel];

  assign upd_en  = fill_acc | hit;
  assign upd_idx = fill_acc ? victim_idx : sel;

  itlb_plru u_plru (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (lru_wr_en),
    .wr_data (lru_wr_data),
    .upd_en  (upd_en),
    .upd_idx (upd_idx),
    .state   (lru_state),
    .victim  (victim_idx),
    .err     (lru_err)
  );

  p_status_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit, miss, multi_hit}));
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_en |-> !(hit || miss || multi_hit));
  p_ready_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lru_wr_en |-> !fill_ready);
  p_multi_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (multi_hit && !fill_valid && !lru_wr_en) |=> $stable(lru_state));
endmodule

// File: tb/ifetch_tlb4_bench.sv
module ifetch_tlb4_bench;
  localparam int TCK = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic lkp_en, use_asid, fill_valid, fill_ready, fill_shr, fill_ent_vld, lru_wr_en;
  logic [31:0] lkp_va;
  logic [7:0]  cur_asid, fill_asid;
  logic [21:0] fill_vpn;
  logic [18:0] fill_ppn, hit_ppn;
  logic [1:0]  fill_size, fill_prot, hit_idx, hit_prot, victim_idx;
  logic [5:0]  lru_wr_data, lru_state;
  logic [28:0] hit_pa;
  logic hit, miss, multi_hit, lru_err;

  int n_chk = 0;
  int n_err = 0;

  logic        mvld [4];
  logic        mshr [4];
  logic [7:0]  masid[4];
  logic [21:0] mvpn [4];
  logic [18:0] mppn [4];
  logic [1:0]  msz  [4];
  logic [1:0]  mprot[4];
  logic [5:0]  mlru;

  always #(TCK/2) clk = ~clk;

  ifetch_tlb4 u_ifetch_tlb4 (
    .clk(clk), .rst_n(rst_n), .lkp_en(lkp_en), .lkp_va(lkp_va),
    .cur_asid(cur_asid), .use_asid(use_asid), .fill_valid(fill_valid),
    .fill_ready(fill_ready), .fill_vpn(fill_vpn), .fill_asid(fill_asid),
    .fill_ppn(fill_ppn), .fill_size(fill_size), .fill_prot(fill_prot),
    .fill_shr(fill_shr), .fill_ent_vld(fill_ent_vld), .lru_wr_en(lru_wr_en),
    .lru_wr_data(lru_wr_data), .hit(hit), .miss(miss), .multi_hit(multi_hit),
    .hit_idx(hit_idx), .hit_prot(hit_prot), .hit_ppn(hit_ppn), .hit_pa(hit_pa),
    .lru_state(lru_state), .victim_idx(victim_idx), .lru_err(lru_err)
  );

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // R2 touch rule, bit by bit
  function automatic logic [5:0] m_touch(input logic [5:0] s, input int i);
    logic [5:0] n = s;
    if (i == 0) begin n[5] = 0; n[4] = 0; n[3] = 0; end
    if (i == 1) begin n[5] = 1; n[2] = 0; n[1] = 0; end
    if (i == 2) begin n[4] = 1; n[2] = 1; n[0] = 0; end
    if (i == 3) begin n[3] = 1; n[1] = 1; n[0] = 1; end
    return n;
  endfunction

  // R3 victim rule: returns {err, victim}
  function automatic logic [2:0] m_victim(input logic [5:0] s);
    if (s[5] & s[4] & s[3])        return 3'b000;
    if (!s[5] & s[2] & s[1])       return 3'b001;
    if (!s[4] & !s[2] & s[0])      return 3'b010;
    if (!s[3] & !s[1] & !s[0])     return 3'b011;
    return 3'b100;
  endfunction

  function automatic int shf(input logic [1:0] z);
    return (z == 0) ? 10 : (z == 1) ? 12 : (z == 2) ? 16 : 20;
  endfunction

  task automatic lru_write(input logic [5:0] s);
    logic [2:0] ev;
    @(negedge clk);
    lru_wr_en = 1'b1; lru_wr_data = s;
    #1 check("R8", "fill_ready during load", 64'(fill_ready), 64'(0));
    @(negedge clk);
    lru_wr_en = 1'b0;
    mlru = s;
    ev = m_victim(s);
    #1;
    check("R8", "loaded state", 64'(lru_state), 64'(s));
    check("R3", "victim", 64'(victim_idx), 64'(ev[1:0]));
    check("R3", "err flag", 64'(lru_err), 64'(ev[2]));
  endtask

  task automatic do_fill(input logic [21:0] vpn, input logic [7:0] asid,
                         input logic [18:0] ppn, input logic [1:0] sz,
                         input logic [1:0] prot, input logic shr, input logic v);
    logic [2:0] ev;
    int k;
    @(negedge clk);
    fill_valid = 1'b1; fill_vpn = vpn; fill_asid = asid; fill_ppn = ppn;
    fill_size = sz; fill_prot = prot; fill_shr = shr; fill_ent_vld = v;
    ev = m_victim(mlru);
    k = int'(ev[1:0]);
    #1 check("R7", "fill_ready", 64'(fill_ready), 64'(1));
    check("R3", "victim at fill", 64'(victim_idx), 64'(ev[1:0]));
    @(negedge clk);
    fill_valid = 1'b0;
    mvld[k] = v; mshr[k] = shr; masid[k] = asid; mvpn[k] = vpn;
    mppn[k] = ppn; msz[k] = sz; mprot[k] = prot;
    mlru = m_touch(mlru, k);
    #1 check("R7", "state after fill", 64'(lru_state), 64'(mlru));
  endtask

  task automatic do_lookup(input logic [31:0] va, input logic [7:0] asid,
                           input logic ua, input logic en);
    int cnt = 0;
    int first = -1;
    int sh;
    logic [31:0] b, p32;
    @(negedge clk);
    lkp_en = en; lkp_va = va; cur_asid = asid; use_asid = ua;
    for (int i = 0; i < 4; i++) begin
      sh = shf(msz[i]);
      b = {mvpn[i], 10'b0};
      if (mvld[i] && (mshr[i] || !ua || masid[i] == asid) && ((va >> sh) == (b >> sh))) begin
        cnt++;
        if (first < 0) first = i;
      end
    end
    #1;
    if (!en) begin
      check("R9", "idle status", 64'({hit, miss, multi_hit}), 64'(0));
    end else begin
      check("R4", "hit", 64'(hit), 64'(cnt == 1));
      check("R4", "miss", 64'(miss), 64'(cnt == 0));
      check("R6", "multi_hit", 64'(multi_hit), 64'(cnt > 1));
      if (cnt == 1) begin
        sh = shf(msz[first]);
        p32 = {3'b0, mppn[first], 10'b0};
        p32 = ((p32 >> sh) << sh) | (va & ((32'd1 << sh) - 32'd1));
        check("R4", "hit_idx", 64'(hit_idx), 64'(first));
        check("R5", "hit_pa", 64'(hit_pa), 64'(p32[28:0]));
        check("R5", "hit_ppn", 64'(hit_ppn), 64'(mppn[first]));
        check("R5", "hit_prot", 64'(hit_prot), 64'(mprot[first]));
      end
    end
    @(negedge clk);
    lkp_en = 1'b0;
    if (en && cnt == 1) mlru = m_touch(mlru, first);
    #1 check(en ? "R2" : "R9", "state after lookup", 64'(lru_state), 64'(mlru));
  endtask

  task automatic sweep(input logic [31:0] lo, input logic [31:0] hi);
    logic [7:0] asids [3] = '{8'd5, 8'd7, 8'd9};
    for (logic [31:0] a = lo; a < hi; a += 32'h400) begin
      for (int o = 0; o < 2; o++) begin
        for (int s = 0; s < 3; s++) begin
          for (int u = 0; u < 2; u++) begin
            do_lookup(a | (o == 1 ? 32'h3FF : 32'h0), asids[s], u[0], 1'b1);
          end
        end
      end
    end
  endtask

  initial begin
    #(TCK * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [5:0] pick [4] = '{6'b111000, 6'b000110, 6'b000001, 6'b000000};
    rst_n = 1'b0; lkp_en = 0; lkp_va = 0; cur_asid = 0; use_asid = 0;
    fill_valid = 0; fill_vpn = 0; fill_asid = 0; fill_ppn = 0; fill_size = 0;
    fill_prot = 0; fill_shr = 0; fill_ent_vld = 0; lru_wr_en = 0; lru_wr_data = 0;
    for (int i = 0; i < 4; i++) begin
      mvld[i] = 0; mshr[i] = 0; masid[i] = 0; mvpn[i] = 0;
      mppn[i] = 0; msz[i] = 0; mprot[i] = 0;
    end
    mlru = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1", "reset state", 64'(lru_state), 64'(0));
    check("R1", "reset victim", 64'(victim_idx), 64'(3));
    check("R1", "reset err", 64'(lru_err), 64'(0));
    do_lookup(32'h0, 8'd0, 1'b0, 1'b1);
    do_lookup(32'h0040_0000, 8'd5, 1'b0, 1'b1);

    // every state value: load, then fill from it
    for (int s = 0; s < 64; s++) begin
      lru_write(6'(s));
      do_fill(22'h30000 + 22'(s), 8'(s), 19'(s), 2'(s), 2'(s), 1'b0, 1'b1);
    end

    // deterministic slot contents, each placed via a chosen state
    lru_write(pick[0]); do_fill(22'h01000, 8'd5, 19'h12345, 2'd0, 2'd0, 1'b0, 1'b1);
    lru_write(pick[1]); do_fill(22'h01004, 8'd3, 19'h0ABCD, 2'd1, 2'd1, 1'b1, 1'b1);
    lru_write(pick[2]); do_fill(22'h01040, 8'd7, 19'h1F0F0, 2'd2, 2'd2, 1'b0, 1'b1);
    lru_write(pick[3]); do_fill(22'h02400, 8'd9, 19'h00777, 2'd3, 2'd3, 1'b0, 1'b1);
    sweep(32'h003F_F000, 32'h0042_1000);
    sweep(32'h008F_F000, 32'h0090_1000);

    // R9: matching address with lookup strobe low
    do_lookup(32'h0040_0010, 8'd5, 1'b1, 1'b0);

    // overlapping 1 MiB page in slot 3: multiple hits (R6)
    lru_write(pick[3]); do_fill(22'h01000, 8'd9, 19'h00777, 2'd3, 2'd3, 1'b0, 1'b1);
    sweep(32'h003F_F000, 32'h0042_1000);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule